// File: doc/BRIEF.md
# State Occupancy Profiling Counter Bank

This block sits beside a state machine that has been instrumented for profiling. On each clock it looks at the encoded state the machine is in and adds one to the counter for that state. From these counts a host can see where the machine spends its time. A free-running global cycle counter runs alongside the per-state counters, so the host can turn each count into a fraction of the total elapsed time.

Each counter stops at all-ones and raises a sticky overflow flag. The flags are gathered into one mask. A small memory-mapped register port lets the host read any count, the cycle total or the overflow mask while the monitored design keeps running. Through the same port the host writes a control word that can clear all counts and flags, or freeze all counting.

Top module: `state_prof_bank`

## Requirements
- R1: Counter i (word address i, 0 to NUM_CNT-1) adds one on every clock edge where `state_i` equals i and counting is not frozen. Every other state counter holds its value on that edge.
- R2: The global cycle counter (word address NUM_CNT, default 16) adds one on every clock edge where counting is not frozen.
- R3: A counter that holds all-ones stays at all-ones when it is asked to count again. On that edge its overflow flag is set, and the flag stays set until a clear. The overflow mask (word address NUM_CNT+1, default 17) holds state counter i's flag in bit i and the cycle counter's flag in bit NUM_CNT. All higher bits read as zero.
- R4: A write to the control word (address NUM_CNT+2, default 18) with bit 0 set zeroes every counter and every overflow flag on that edge. The clear wins over an increment on the same edge. Bit 0 always reads back as 0.
- R5: Bit 1 of the control word is the freeze bit. A write stores it, and it reads back in bit 1. From the edge after the write, every counter holds its value while the bit is 1. A clear still works while counting is frozen.
- R6: A read (`req_i`=1, `we_i`=0) sampled on edge t drives `rvalid_o` high and `rdata_o` with the addressed word during the following cycle. The word is the value the register held just before edge t, even if that edge also changes the register. `rvalid_o` is low in every cycle that does not follow a read.
- R7: A read of any address above NUM_CNT+2 returns zero. A write to any address other than the control word changes nothing.
- R8: After reset, all counters, flags and the freeze bit are zero, and `rvalid_o` and `rdata_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| state_i | input | SEL_W (4) | Encoded state of the monitored machine |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (5) | Word address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, valid while rvalid_o is high |
| rvalid_o | output | 1 | Read data valid, one cycle after the request |

## Verification
Counter updates, clears and writes to the freeze bit all take effect on the edge that samples them. A freeze reaches the counters one edge later. Read data appears one cycle after the request, and it holds the register's contents from before the request edge. The bench drives its inputs on the falling edge. It computes the expected read word from its model at that moment, before it applies that edge's update. It then compares `rdata_o` and `rvalid_o` on the next falling edge. The bench uses an 8-bit counter width so that saturation and overflow can be reached in a few hundred cycles.

// File: rtl/prof_pkg.sv
package prof_pkg;
  localparam int CTRL_CLR_BIT  = 0;
  localparam int CTRL_STOP_BIT = 1;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_CNT,
    RSEL_CYC,
    RSEL_OVF,
    RSEL_CTRL
  } rsel_e;
endpackage

// File: rtl/prof_counter.sv
module prof_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] MAX_V = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (inc_i) begin
      if (cnt_o == MAX_V) ovf_o <= 1'b1;
      else                cnt_o <= cnt_o + 1'b1;
    end
  end

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX_V && !clr_i) |=> cnt_o == MAX_V); // R3
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o); // R3
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0 && !ovf_o)); // R4
  AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1)); // R1
endmodule

// File: rtl/prof_ctrl.sv
module prof_ctrl #(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32,
  parameter int CTRL_ADDR = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              clr_o,
  output logic              stop_o
);
  import prof_pkg::*;

  logic ctrl_wr;
  assign ctrl_wr = req_i && we_i && (addr_i == ADDR_W'(CTRL_ADDR));
  assign clr_o   = ctrl_wr && wdata_i[CTRL_CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stop_o <= 1'b0;
    else if (ctrl_wr) stop_o <= wdata_i[CTRL_STOP_BIT];
  end

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == ADDR_W'(CTRL_ADDR)) |=> $stable(stop_o)); // R7
endmodule

// File: rtl/prof_rdmux.sv
module prof_rdmux #(
  parameter int NUM_CNT = 16,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  localparam int SEL_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
  localparam int MASK_W = NUM_CNT + 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0]              cyc_i,
  input  logic [MASK_W-1:0]             ovf_i,
  input  logic                          stop_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          rvalid_o
);
  import prof_pkg::*;

  localparam int CYC_ADDR  = NUM_CNT;
  localparam int OVF_ADDR  = NUM_CNT + 1;
  localparam int CTRL_ADDR = NUM_CNT + 2;

  rsel_e             rsel;
  logic [DATA_W-1:0] rd_next;
  logic              rd_req;

  assign rd_req = req_i && !we_i;

  always_comb begin
    if (addr_i < ADDR_W'(NUM_CNT))         rsel = RSEL_CNT;
    else if (addr_i == ADDR_W'(CYC_ADDR))  rsel = RSEL_CYC;
    else if (addr_i == ADDR_W'(OVF_ADDR))  rsel = RSEL_OVF;
    else if (addr_i == ADDR_W'(CTRL_ADDR)) rsel = RSEL_CTRL;
    else                                   rsel = RSEL_NONE;
  end

  always_comb begin
    rd_next = '0;
    unique case (rsel)
      RSEL_CNT:  rd_next = DATA_W'(cnt_i[addr_i[SEL_W-1:0]]);
      RSEL_CYC:  rd_next = DATA_W'(cyc_i);
      RSEL_OVF:  rd_next = DATA_W'(ovf_i);
      RSEL_CTRL: rd_next[CTRL_STOP_BIT] = stop_i;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= rd_next;
    end
  end

  AST_RVALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o); // R6
  AST_RVALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rvalid_o); // R6
endmodule

// File: rtl/state_prof_bank.sv
module state_prof_bank #(
  parameter int NUM_CNT = 16,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  localparam int SEL_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
  localparam int MASK_W = NUM_CNT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  state_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int CTRL_ADDR = NUM_CNT + 2;

  logic                          clr;
  logic                          stop;
  logic [NUM_CNT-1:0]            inc;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0]            cnt_ovf;
  logic [CNT_W-1:0]              cyc;
  logic                          cyc_ovf;

  prof_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .clr_o  (clr),
    .stop_o (stop)
  );

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    assign inc[gi] = !stop && (state_i == SEL_W'(gi));
    prof_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (clr),
      .inc_i (inc[gi]),
      .cnt_o (cnt[gi]),
      .ovf_o (cnt_ovf[gi])
    );
  end

  prof_counter #(.CNT_W(CNT_W)) u_cyc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .inc_i (!stop),
    .cnt_o (cyc),
    .ovf_o (cyc_ovf)
  );

  prof_rdmux #(
    .NUM_CNT(NUM_CNT),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .cnt_i   (cnt),
    .cyc_i   (cyc),
    .ovf_i   ({cyc_ovf, cnt_ovf}),
    .stop_i  (stop),
    .rdata_o (rdata_o),
    .rvalid_o(rvalid_o)
  );

  AST_ONE_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inc)); // R1
  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !clr) |=> $stable(cyc) && $stable(cnt)); // R5
  AST_CYC_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop && !clr && cyc != '1) |=> cyc == $past(cyc) + 1'b1); // R2
endmodule

// File: tb/sim_state_prof_bank.sv
module sim_state_prof_bank;
  localparam int NC   = 16;
  localparam int CW   = 8;
  localparam int MAXV = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  state = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;

  always #4 clk = ~clk;

  state_prof_bank #(.NUM_CNT(NC), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .state_i(state), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid)
  );

  int unsigned m_cnt [NC];
  int unsigned m_cyc;
  logic [NC:0] m_ovf;
  bit          m_stop;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;
  bit          pend = 0;
  logic [31:0] pend_exp;
  string       pend_tag;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [4:0] a);
    if (a < NC)      return m_cnt[a];
    if (a == NC)     return m_cyc;
    if (a == NC + 1) return 32'(m_ovf);
    if (a == NC + 2) return {30'd0, m_stop, 1'b0};
    return 32'd0;
  endfunction

  function automatic string tag_of(input logic [4:0] a);
    if (a < NC)      return "R1";
    if (a == NC)     return "R2";
    if (a == NC + 1) return "R3";
    if (a == NC + 2) return "R5";
    return "R7";
  endfunction

  // model of one edge, from the requirements
  task automatic model_edge(input logic [3:0] s, input bit rq, input bit w,
                            input logic [4:0] a, input logic [31:0] wd);
    bit cw = rq && w && (a == NC + 2);
    if (cw && wd[0]) begin
      for (int i = 0; i < NC; i++) m_cnt[i] = 0;
      m_cyc = 0;
      m_ovf = '0;
    end else if (!m_stop) begin
      if (m_cnt[s] == MAXV) m_ovf[s] = 1'b1; else m_cnt[s]++;
      if (m_cyc == MAXV) m_ovf[NC] = 1'b1; else m_cyc++;
    end
    if (cw) m_stop = wd[1];
  endtask

  task automatic step(input logic [3:0] s, input bit rq, input bit w,
                      input logic [4:0] a, input logic [31:0] wd, input string tag);
    @(negedge clk);
    if (pend) begin
      chk(rvalid === 1'b1, "R6", 32'(rvalid), 32'd1);
      chk(rdata === pend_exp, pend_tag, rdata, pend_exp);
    end
    state = s; req = rq; we = w; addr = a; wdata = wd;
    pend = rq && !w;
    if (pend) begin
      pend_exp = model_read(a);
      pend_tag = (tag == "") ? tag_of(a) : tag;
    end
    model_edge(s, rq, w, a, wd);
    @(posedge clk);
  endtask

  task automatic rd(input logic [3:0] s, input logic [4:0] a, input string tag);
    step(s, 1'b1, 1'b0, a, 32'd0, tag);
  endtask

  task automatic wr_ctrl(input logic [3:0] s, input logic [31:0] wd);
    step(s, 1'b1, 1'b1, 5'(NC + 2), wd, "");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog got=0 exp=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < NC; i++) m_cnt[i] = 0;
    m_cyc = 0; m_ovf = '0; m_stop = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state at the ports
    chk(rvalid === 1'b0, "R8", 32'(rvalid), 32'd0);
    chk(rdata === 32'd0, "R8", rdata, 32'd0);
    rst_n = 1'b1;
    @(posedge clk);
    // this edge counted with state 0
    model_edge(4'd0, 1'b0, 1'b0, 5'd0, 32'd0);
    for (int a = 0; a <= NC + 2; a++) rd(4'd9, 5'(a), "R8");
    step(4'd9, 1'b0, 1'b0, 5'd0, 32'd0, "");
    // R6: rvalid low after an idle cycle
    @(negedge clk);
    chk(rvalid === 1'b0, "R6", 32'(rvalid), 32'd0);
    @(posedge clk);
    model_edge(4'd9, 1'b0, 1'b0, 5'd0, 32'd0);

    // R4: clear, then all registers read zero
    wr_ctrl(4'd2, 32'h1);
    for (int a = 0; a <= NC + 2; a++) rd(4'd1, 5'(a), "");

    // R1 R6: coherent read of a counter that increments on the same edge
    for (int k = 0; k < 6; k++) rd(4'd7, 5'd7, "R6");

    // R3: saturate counter 3 and the cycle counter
    wr_ctrl(4'd3, 32'h1);
    for (int k = 0; k < 300; k++) step(4'd3, 1'b0, 1'b0, 5'd0, 32'd0, "");
    rd(4'd3, 5'd3, "R3");
    rd(4'd3, 5'(NC), "R3");
    rd(4'd3, 5'(NC + 1), "R3");

    // R4: clear wins over increment, while freeze set too
    wr_ctrl(4'd3, 32'h3);
    rd(4'd3, 5'd3, "R4");
    rd(4'd3, 5'(NC + 1), "R4");
    rd(4'd3, 5'(NC + 2), "R5");
    // R5: frozen counts hold
    for (int k = 0; k < 10; k++) step(4'd5, 1'b0, 1'b0, 5'd0, 32'd0, "");
    rd(4'd5, 5'd5, "R5");
    rd(4'd5, 5'(NC), "R5");
    wr_ctrl(4'd5, 32'h0);
    for (int k = 0; k < 4; k++) step(4'd5, 1'b0, 1'b0, 5'd0, 32'd0, "");
    rd(4'd5, 5'd5, "R5");

    // R7: writes outside the control word are ignored; high addresses read 0
    step(4'd1, 1'b1, 1'b1, 5'd5, 32'hFFFF_FFFF, "");
    step(4'd1, 1'b1, 1'b1, 5'(NC + 1), 32'hFFFF_FFFF, "");
    step(4'd1, 1'b1, 1'b1, 5'd31, 32'h3, "");
    rd(4'd1, 5'd5, "R7");
    rd(4'd1, 5'(NC + 1), "R7");
    rd(4'd1, 5'(NC + 2), "R7");
    rd(4'd1, 5'd31, "R7");
    rd(4'd1, 5'd20, "R7");

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      int unsigned r = $urandom_range(0, 999);
      logic [3:0] s = 4'($urandom_range(0, NC - 1));
      if (r < 5)       wr_ctrl(s, 32'h1);
      else if (r < 15) wr_ctrl(s, {30'd0, 1'($urandom_range(0, 1)), 1'b0});
      else if (r < 30) step(s, 1'b1, 1'b1, 5'($urandom_range(0, 31)),
                            $urandom & 32'hFFFF_FFFE, "");
      else if (r < 300) rd(s, 5'($urandom_range(0, 31)), "");
      else             step(s, 1'b0, 1'b0, 5'd0, 32'd0, "");
    end
    for (int a = 0; a <= NC + 2; a++) rd(4'($urandom_range(0, NC - 1)), 5'(a), "");
    step(4'd0, 1'b0, 1'b0, 5'd0, 32'd0, "");
    finish_run();
  end
endmodule